// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the controller for a processor datapath that has one memory port for both instructions and data and one ALU for all arithmetic. The datapath cannot do every step of an instruction at once. This controller therefore runs each instruction as a short series of cycles: fetch, decode, then one to three class-specific cycles. In each cycle it raises exactly the enables and multiplexer selects that this step needs.

The only instruction input is the 6-bit opcode field, which the datapath holds steady in its instruction register. All outputs are decoded from the current state alone. The current state code is also brought out so that the datapath, or a test, can follow the sequence.

Fetch loads the instruction register and advances the program counter by four. Decode lets the register file fill its operand latches and uses the idle ALU to form the branch target early. The later steps do the following:
- form a load/store address;
- access memory;
- run a register-register operation;
- resolve a branch or a jump;
- write a result back.

A load takes 5 cycles. A store and a register-register operation each take 4. A branch and a jump each take 3.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low, and asynchronously on its fall, state_o is 0 (fetch) and the outputs carry the fetch vector.
- R2: In fetch (state 0): mem_rd_o=1, ir_wr_o=1, pc_wr_o=1, pc_src_o=00, addr_sel_o=0, alu_a_sel_o=0, alu_b_sel_o=01 (constant four), alu_op_o=00 (add). Every other control is 0, and the next state is always 1.
- R3: In decode (state 1): alu_a_sel_o=0, alu_b_sel_o=11 (shifted offset), alu_op_o=00, and every other control is 0. The next state follows opcode_i: 0x23 or 0x2B give 2, 0x00 gives 6, 0x04 gives 8, 0x02 gives 9.
- R4: A load (0x23) visits states 0,1,2,3,4 and then returns to 0. The vectors are as follows:
  - State 2: alu_a_sel_o=1, alu_b_sel_o=10 (immediate), alu_op_o=00.
  - State 3: mem_rd_o=1, addr_sel_o=1.
  - State 4: rf_wr_o=1, wb_sel_o=1, rf_dst_o=0.
- R5: A store (0x2B) visits states 0,1,2,5 and then returns to 0. State 5 drives mem_wr_o=1 and addr_sel_o=1.
- R6: A register-register operation (0x00) visits states 0,1,6,7 and then returns to 0. The vectors are as follows:
  - State 6: alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=10 (function field).
  - State 7: rf_wr_o=1, rf_dst_o=1, wb_sel_o=0.
- R7: A branch (0x04) visits states 0,1,8 and then returns to 0. State 8 drives pc_wr_cond_o=1, pc_src_o=01, alu_a_sel_o=1, alu_b_sel_o=00 and alu_op_o=01 (subtract), with pc_wr_o=0.
- R8: A jump (0x02) visits states 0,1,9 and then returns to 0. State 9 drives pc_wr_o=1 and pc_src_o=10.
- R9: Any other opcode in decode returns the sequencer to state 0 on the next edge.
- R10: mem_rd_o and mem_wr_o are never high together, and neither are pc_wr_o and pc_wr_cond_o. Every control not named for a state is 0 in that state.
- R11: opcode_i is read only in states 1 and 2. Changing it in any other state does not alter the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 6 | Opcode field of the held instruction |
| state_o | output | 4 | Current step code, 0 to 9 |
| pc_wr_o | output | 1 | Unconditional program counter write |
| pc_wr_cond_o | output | 1 | Program counter write if ALU zero |
| pc_src_o | output | 2 | PC source: 00 ALU result, 01 ALU latch, 10 jump target |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU latch |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| wb_sel_o | output | 1 | Write-back data: 0 ALU latch, 1 memory data latch |
| ir_wr_o | output | 1 | Instruction register load |
| alu_a_sel_o | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B: 00 reg B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | ALU op: 00 add, 01 subtract, 10 function field |
| rf_wr_o | output | 1 | Register file write |
| rf_dst_o | output | 1 | Destination: 0 rt field, 1 rd field |

## Verification
Each of the five opcode classes is run, together with an unsupported opcode. Because the classes share their first two states, only the step sequences taken from decode and from the address state can tell them apart: load from store, and the three-cycle branch from the jump. At every step the full 16-bit control vector is compared, so a wrong select in a shared state shows up under every class. Further tests change the opcode during an execute step and during a branch to show that it is not read there, and assert reset in the middle of an instruction.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int unsigned STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MRD    = 4'd3,
    ST_MWB    = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXE    = 4'd6,
    ST_RWB    = 4'd7,
    ST_BR     = 4'd8,
    ST_JMP    = 4'd9
  } state_e;

  typedef enum logic [1:0] {
    PCS_ALU = 2'b00,
    PCS_LAT = 2'b01,
    PCS_JMP = 2'b10
  } pc_src_e;

  typedef enum logic [1:0] {
    BSEL_REG  = 2'b00,
    BSEL_FOUR = 2'b01,
    BSEL_IMM  = 2'b10,
    BSEL_IMMS = 2'b11
  } b_sel_e;

  typedef enum logic [1:0] {
    AOP_ADD  = 2'b00,
    AOP_SUB  = 2'b01,
    AOP_FUNC = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    pc_wr;
    logic    pc_wr_cond;
    pc_src_e pc_src;
    logic    addr_sel;
    logic    mem_rd;
    logic    mem_wr;
    logic    wb_sel;
    logic    ir_wr;
    logic    alu_a_sel;
    b_sel_e  alu_b_sel;
    alu_op_e alu_op;
    logic    rf_wr;
    logic    rf_dst;
  } ctrl_t;
endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned      OPC_W   = 6,
  parameter logic [OPC_W-1:0] OPC_LD  = 6'h23,
  parameter logic [OPC_W-1:0] OPC_ST  = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_RR  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_BEQ = 6'h04,
  parameter logic [OPC_W-1:0] OPC_JMP = 6'h02
) (
  input  state_e           state_i,
  input  logic [OPC_W-1:0] opcode_i,
  output state_e           state_o
);
  always_comb begin
    state_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:  state_o = ST_DECODE;
      ST_DECODE: begin
        if (opcode_i == OPC_LD || opcode_i == OPC_ST) state_o = ST_MADDR;
        else if (opcode_i == OPC_RR)                  state_o = ST_EXE;
        else if (opcode_i == OPC_BEQ)                 state_o = ST_BR;
        else if (opcode_i == OPC_JMP)                 state_o = ST_JMP;
        else                                          state_o = ST_FETCH;
      end
      // address is shared; the opcode is re-read to split load from store
      ST_MADDR:  state_o = (opcode_i == OPC_ST) ? ST_MWR : ST_MRD;
      ST_MRD:    state_o = ST_MWB;
      ST_EXE:    state_o = ST_RWB;
      ST_MWB, ST_MWR, ST_RWB, ST_BR, ST_JMP: state_o = ST_FETCH;
      default:   state_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_dec.sv
module mc_ctrl_dec
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.pc_src    = PCS_ALU;
        ctrl_o.alu_b_sel = BSEL_FOUR;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_DECODE: begin
        // idle ALU forms the branch target ahead of time
        ctrl_o.alu_b_sel = BSEL_IMMS;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_MADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_IMM;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_MRD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_MWB: begin
        ctrl_o.rf_wr  = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      ST_MWR: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_EXE: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_REG;
        ctrl_o.alu_op    = AOP_FUNC;
      end
      ST_RWB: begin
        ctrl_o.rf_wr  = 1'b1;
        ctrl_o.rf_dst = 1'b1;
      end
      ST_BR: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = BSEL_REG;
        ctrl_o.alu_op     = AOP_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = PCS_LAT;
      end
      ST_JMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = PCS_JMP;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned      OPC_W   = 6,
  parameter logic [OPC_W-1:0] OPC_LD  = 6'h23,
  parameter logic [OPC_W-1:0] OPC_ST  = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_RR  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_BEQ = 6'h04,
  parameter logic [OPC_W-1:0] OPC_JMP = 6'h02
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OPC_W-1:0]   opcode_i,
  output logic [STATE_W-1:0] state_o,
  output logic               pc_wr_o,
  output logic               pc_wr_cond_o,
  output logic [1:0]         pc_src_o,
  output logic               addr_sel_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               wb_sel_o,
  output logic               ir_wr_o,
  output logic               alu_a_sel_o,
  output logic [1:0]         alu_b_sel_o,
  output logic [1:0]         alu_op_o,
  output logic               rf_wr_o,
  output logic               rf_dst_o
);
  state_e state_q, state_d;
  ctrl_t  ctrl;

  mc_ctrl_next #(
    .OPC_W  (OPC_W),
    .OPC_LD (OPC_LD),
    .OPC_ST (OPC_ST),
    .OPC_RR (OPC_RR),
    .OPC_BEQ(OPC_BEQ),
    .OPC_JMP(OPC_JMP)
  ) u_next (
    .state_i (state_q),
    .opcode_i(opcode_i),
    .state_o (state_d)
  );

  mc_ctrl_dec u_dec (
    .state_i(state_q),
    .ctrl_o (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign pc_src_o     = ctrl.pc_src;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign wb_sel_o     = ctrl.wb_sel;
  assign ir_wr_o      = ctrl.ir_wr;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign rf_wr_o      = ctrl.rf_wr;
  assign rf_dst_o     = ctrl.rf_dst;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
  parameter int unsigned      OPC_W   = 6,
  parameter logic [OPC_W-1:0] OPC_LD  = 6'h23,
  parameter logic [OPC_W-1:0] OPC_ST  = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_RR  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_BEQ = 6'h04,
  parameter logic [OPC_W-1:0] OPC_JMP = 6'h02
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OPC_W-1:0] opcode_i,
  input logic [3:0]       state_o,
  input logic             pc_wr_o,
  input logic             pc_wr_cond_o,
  input logic [1:0]       pc_src_o,
  input logic             addr_sel_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             wb_sel_o,
  input logic             ir_wr_o,
  input logic             alu_a_sel_o,
  input logic [1:0]       alu_b_sel_o,
  input logic [1:0]       alu_op_o,
  input logic             rf_wr_o,
  input logic             rf_dst_o
);
  p_fetch_to_decode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> state_o == 4'd1);
  p_fetch_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |-> (!alu_a_sel_o && alu_b_sel_o == 2'b01 && !addr_sel_o));
  p_dec_ld_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && opcode_i == OPC_LD) |=> state_o == 4'd2);
  p_dec_rr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && opcode_i == OPC_RR) |=> state_o == 4'd6);
  p_ld_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd2 && opcode_i == OPC_LD) |=> (mem_rd_o && addr_sel_o));
  p_ld_wb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_sel_o |-> (rf_wr_o && !rf_dst_o));
  p_st_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd2 && opcode_i == OPC_ST) |=> mem_wr_o);
  p_rr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_o == 2'b10) |=> (rf_wr_o && rf_dst_o));
  p_br_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |-> (alu_op_o == 2'b01 && pc_src_o == 2'b01));
  p_br_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && opcode_i == OPC_BEQ) |=> pc_wr_cond_o);
  p_jmp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && opcode_i == OPC_JMP) |=> (pc_wr_o && pc_src_o == 2'b10));
  p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_wr_o || mem_wr_o || pc_wr_cond_o || pc_src_o == 2'b10) |=> state_o == 4'd0);
  p_mem_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  p_pc_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pc_wr_o && pc_wr_cond_o));
  p_addr_use_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_sel_o |-> (mem_rd_o || mem_wr_o));
  p_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 4'd9);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(
  .OPC_W  (OPC_W),
  .OPC_LD (OPC_LD),
  .OPC_ST (OPC_ST),
  .OPC_RR (OPC_RR),
  .OPC_BEQ(OPC_BEQ),
  .OPC_JMP(OPC_JMP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .opcode_i    (opcode_i),
  .state_o     (state_o),
  .pc_wr_o     (pc_wr_o),
  .pc_wr_cond_o(pc_wr_cond_o),
  .pc_src_o    (pc_src_o),
  .addr_sel_o  (addr_sel_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .wb_sel_o    (wb_sel_o),
  .ir_wr_o     (ir_wr_o),
  .alu_a_sel_o (alu_a_sel_o),
  .alu_b_sel_o (alu_b_sel_o),
  .alu_op_o    (alu_op_o),
  .rf_wr_o     (rf_wr_o),
  .rf_dst_o    (rf_dst_o)
);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'h00;
  logic [3:0] state_o;
  logic pc_wr_o, pc_wr_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, wb_sel_o;
  logic ir_wr_o, alu_a_sel_o, rf_wr_o, rf_dst_o;
  logic [1:0] pc_src_o, alu_b_sel_o, alu_op_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mc_ctrl_fsm u_dut (
    .clk_i, .rst_ni, .opcode_i, .state_o, .pc_wr_o, .pc_wr_cond_o, .pc_src_o,
    .addr_sel_o, .mem_rd_o, .mem_wr_o, .wb_sel_o, .ir_wr_o, .alu_a_sel_o,
    .alu_b_sel_o, .alu_op_o, .rf_wr_o, .rf_dst_o
  );

  // {pc_wr,pc_wr_cond,pc_src,addr_sel,mem_rd,mem_wr,wb_sel,ir_wr,alu_a,alu_b,alu_op,rf_wr,rf_dst}
  logic [15:0] act;
  assign act = {pc_wr_o, pc_wr_cond_o, pc_src_o, addr_sel_o, mem_rd_o, mem_wr_o,
                wb_sel_o, ir_wr_o, alu_a_sel_o, alu_b_sel_o, alu_op_o, rf_wr_o, rf_dst_o};

  localparam logic [15:0] CTRL_TBL [10] = '{
    16'b1_0_00_0_1_0_0_1_0_01_00_0_0,
    16'b0_0_00_0_0_0_0_0_0_11_00_0_0,
    16'b0_0_00_0_0_0_0_0_1_10_00_0_0,
    16'b0_0_00_1_1_0_0_0_0_00_00_0_0,
    16'b0_0_00_0_0_0_1_0_0_00_00_1_0,
    16'b0_0_00_1_0_1_0_0_0_00_00_0_0,
    16'b0_0_00_0_0_0_0_0_1_00_10_0_0,
    16'b0_0_00_0_0_0_0_0_0_00_00_1_1,
    16'b0_1_01_0_0_0_0_0_1_00_01_0_0,
    16'b1_0_10_0_0_0_0_0_0_00_00_0_0
  };

  // {opcode, length, five 4-bit state codes}
  localparam logic [28:0] INSTR_TBL [6] = '{
    {6'h23, 3'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},
    {6'h2B, 3'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},
    {6'h00, 3'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0},
    {6'h04, 3'd3, 4'd0, 4'd1, 4'd8, 4'd0, 4'd0},
    {6'h02, 3'd3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0},
    {6'h3F, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_state(input string req, input logic [3:0] exp);
    chk(req, {12'd0, state_o}, {12'd0, exp});
    chk(req, act, CTRL_TBL[exp]);
    chk("R10", {14'd0, mem_rd_o & mem_wr_o, pc_wr_o & pc_wr_cond_o}, 16'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk_state("R1", 4'd0);
    rst_ni = 1'b1;
    // vector table walk; each iteration samples one negedge per step
    for (int i = 0; i < 6; i++) begin
      opcode_i = INSTR_TBL[i][28:23];
      for (int k = 0; k < int'(INSTR_TBL[i][22:20]); k++) begin
        chk_state(k < 2 ? (k == 0 ? "R2" : "R3") : tag_of(i), INSTR_TBL[i][19-4*k -: 4]);
        @(negedge clk_i);
      end
    end
    chk_state("R9", 4'd0);

    // R11: opcode changed during execute and branch steps is ignored
    opcode_i = 6'h00;
    @(negedge clk_i); @(negedge clk_i);
    chk_state("R6", 4'd6);
    opcode_i = 6'h23;
    @(negedge clk_i);
    chk_state("R11", 4'd7);
    @(negedge clk_i);
    chk_state("R11", 4'd0);
    opcode_i = 6'h04;
    @(negedge clk_i); @(negedge clk_i);
    chk_state("R7", 4'd8);
    opcode_i = 6'h02;
    @(negedge clk_i);
    chk_state("R11", 4'd0);

    // R1: asynchronous reset mid-instruction
    opcode_i = 6'h2B;
    @(negedge clk_i); @(negedge clk_i);
    chk_state("R5", 4'd2);
    rst_ni = 1'b0;
    #1;
    chk_state("R1", 4'd0);
    @(negedge clk_i);
    chk_state("R1", 4'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_state("R2", 4'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule